// File: doc/BRIEF.md
# Two-Dimensional Vector Register File

A storage array of 64 rows by 64 columns of 8-bit cells, built for a vector datapath that wants to walk a tile of data either along a row or down a column without moving it first. Every access moves one vector of 16 lanes. A vector is selected by a base coordinate (y, x), an orientation (horizontal steps the column per lane, vertical steps the row per lane) and an element width of 8, 16 or 32 bits. A wide element is not made of adjacent bytes. Its bytes are cells in the same row, spaced a quarter of the array width apart, so a 32-bit lane spans the four column quarters.

There is one read port and one write port, and both can be used in the same cycle. Each port may add a 12-bit scalar offset to its base. The upper six bits of the offset go to the row and the lower six bits go to the column. All coordinate sums wrap at 64. The write port has one enable per lane. Read data is registered and appears one cycle after the request. Narrow elements are zero-extended into 32-bit lane slots.

Top module: `vrf2d_top`

## Requirements
- R1: While `rst` is high, `rd_valid` and `rd_data` go to zero at the next clock edge. No write is performed while `rst` is high.
- R2: `rd_valid` is high exactly one cycle after each cycle in which `rd_en` was high. `rd_data` keeps its value through cycles with no read.
- R3: With `*_vert`=0, lane k (k=0..15) addresses row y, column x+k.
- R4: With `*_vert`=1, lane k addresses row y+k, column x.
- R5: Width code 1 (16 bits): the lane's low byte is the cell at the lane's column c and its high byte is the cell at column c+16. On reads, lane bits [31:16] are zero.
- R6: Width codes 2 and 3 (32 bits): byte j (j=0..3, least significant first) of a lane is the cell at column c+16*j in the lane's row.
- R7: Width code 0 (8 bits): one cell per lane. On reads, lane bits [31:8] are zero.
- R8: With `*_off_en`=1, `off[11:6]` is added to y and `off[5:0]` to x. With `*_off_en`=0, the offset value has no effect.
- R9: Every row and column sum, including the lane step, the byte stride and the offset, wraps modulo 64.
- R10: A write with `wr_en`=1 updates every byte of each lane whose `wr_lane_en[k]` is set. Cells of lanes whose enable is clear keep their contents.
- R11: A read and a write in the same cycle to overlapping cells return the contents from before the write. The new contents are visible to later reads.
- R12: With `wr_en`=0, no cell changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| rd_y | input | 6 | Read base row |
| rd_x | input | 6 | Read base column |
| rd_vert | input | 1 | Read orientation: 0 along a row, 1 down a column |
| rd_width | input | 2 | Read element width code (0: 8, 1: 16, 2/3: 32 bits) |
| rd_off_en | input | 1 | Apply the read offset |
| rd_off | input | 12 | Read offset, row in [11:6], column in [5:0] |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 512 | Read vector; lane k in bits [32k+31:32k] |
| wr_en | input | 1 | Write request |
| wr_y | input | 6 | Write base row |
| wr_x | input | 6 | Write base column |
| wr_vert | input | 1 | Write orientation |
| wr_width | input | 2 | Write element width code |
| wr_off_en | input | 1 | Apply the write offset |
| wr_off | input | 12 | Write offset, row in [11:6], column in [5:0] |
| wr_lane_en | input | 16 | Per-lane write enables |
| wr_data | input | 512 | Write vector; lane k in bits [32k+31:32k] |

## Verification
The assertions assume that `rd_en` and `rd_width` are driven to known levels at every clock edge once reset is released. They check the read handshake and the zero-extension of narrow lanes, and neither of these depends on the array's contents. The array is never reset, so the stimulus writes every cell before it issues the first read, and all reads then return defined data. Inputs change only on the falling clock edge. Random traffic mixes both orientations, all four width codes, offsets with the enable set and clear, and partial lane masks. Directed cases place bases near 63 to force wrap-around.

// File: rtl/vrf2d_pkg.sv
package vrf2d_pkg;
    localparam int COORD_W     = 6;
    localparam int ROWS        = 1 << COORD_W;
    localparam int COLS        = 1 << COORD_W;
    localparam int LANES       = 16;
    localparam int CELL_W      = 8;
    localparam int MAX_BYTES   = 4;
    localparam int LANE_W      = CELL_W * MAX_BYTES;
    localparam int WIDE_STRIDE = COLS / MAX_BYTES;
    localparam int OFF_W       = 2 * COORD_W;
    localparam int SLOTS       = LANES * MAX_BYTES;
    localparam int DATA_W      = LANES * LANE_W;

    typedef logic [COORD_W-1:0] coord_t;

    typedef enum logic [1:0] {
        EW_B8      = 2'd0,
        EW_B16     = 2'd1,
        EW_B32     = 2'd2,
        EW_B32_ALT = 2'd3
    } elem_w_e;

    typedef struct packed {
        coord_t             y;
        coord_t             x;
        logic               vert;
        elem_w_e            ew;
        logic               off_en;
        logic [OFF_W-1:0]   off;
    } vec_req_t;

    typedef struct packed {
        coord_t row;
        coord_t col;
    } cell_ref_t;

    function automatic logic [2:0] bytes_of(elem_w_e ew);
        case (ew)
            EW_B8:   return 3'd1;
            EW_B16:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/vrf2d_addr_gen.sv
module vrf2d_addr_gen
    import vrf2d_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int N_BYTES = MAX_BYTES,
    parameter int STRIDE  = WIDE_STRIDE
) (
    input  vec_req_t                          req,
    output cell_ref_t [N_LANES*N_BYTES-1:0]   cells,
    output logic      [N_LANES*N_BYTES-1:0]   active
);
    coord_t     base_y;
    coord_t     base_x;
    logic [2:0] nbytes;

    // offset applied before any lane or byte step; all sums wrap at COORD_W bits
    always_comb begin
        base_y = req.y;
        base_x = req.x;
        if (req.off_en) begin
            base_y = req.y + req.off[OFF_W-1:COORD_W];
            base_x = req.x + req.off[COORD_W-1:0];
        end
    end

    assign nbytes = bytes_of(req.ew);

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        localparam coord_t LANE_STEP = COORD_W'(l);
        for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
            localparam coord_t     BYTE_STEP = COORD_W'(STRIDE * b);
            localparam logic [2:0] BIDX      = 3'(b);
            localparam int         S         = l * N_BYTES + b;
            assign cells[S].row = req.vert ? coord_t'(base_y + LANE_STEP) : base_y;
            assign cells[S].col = req.vert ? coord_t'(base_x + BYTE_STEP)
                                           : coord_t'(base_x + LANE_STEP + BYTE_STEP);
            assign active[S]    = (BIDX < nbytes);
        end
    end
endmodule

// File: rtl/vrf2d_cell_array.sv
module vrf2d_cell_array
    import vrf2d_pkg::*;
#(
    parameter int N_ROWS  = ROWS,
    parameter int N_COLS  = COLS,
    parameter int N_SLOTS = SLOTS
) (
    input  logic                                clk,
    input  logic                                we,
    input  cell_ref_t [N_SLOTS-1:0]             wcell,
    input  logic      [N_SLOTS-1:0]             wbe,
    input  logic      [N_SLOTS-1:0][CELL_W-1:0] wbyte,
    input  cell_ref_t [N_SLOTS-1:0]             rcell,
    output logic      [N_SLOTS-1:0][CELL_W-1:0] rbyte
);
    localparam int ROW_BITS = N_COLS * CELL_W;

    // one wide word per row keeps the element count at N_ROWS
    logic [ROW_BITS-1:0] rows_q [N_ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < N_SLOTS; i++) begin
                if (wbe[i]) begin
                    rows_q[wcell[i].row][wcell[i].col*CELL_W +: CELL_W] <= wbyte[i];
                end
            end
        end
    end

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_rd
        assign rbyte[i] = rows_q[rcell[i].row][rcell[i].col*CELL_W +: CELL_W];
    end
endmodule

// File: rtl/vrf2d_top.sv
module vrf2d_top
    import vrf2d_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_en,
    input  logic [COORD_W-1:0]   rd_y,
    input  logic [COORD_W-1:0]   rd_x,
    input  logic                 rd_vert,
    input  logic [1:0]           rd_width,
    input  logic                 rd_off_en,
    input  logic [OFF_W-1:0]     rd_off,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 wr_en,
    input  logic [COORD_W-1:0]   wr_y,
    input  logic [COORD_W-1:0]   wr_x,
    input  logic                 wr_vert,
    input  logic [1:0]           wr_width,
    input  logic                 wr_off_en,
    input  logic [OFF_W-1:0]     wr_off,
    input  logic [LANES-1:0]     wr_lane_en,
    input  logic [DATA_W-1:0]    wr_data
);
    vec_req_t rd_req;
    vec_req_t wr_req;

    assign rd_req = '{y: rd_y, x: rd_x, vert: rd_vert, ew: elem_w_e'(rd_width),
                      off_en: rd_off_en, off: rd_off};
    assign wr_req = '{y: wr_y, x: wr_x, vert: wr_vert, ew: elem_w_e'(wr_width),
                      off_en: wr_off_en, off: wr_off};

    cell_ref_t [SLOTS-1:0]             rd_cells;
    cell_ref_t [SLOTS-1:0]             wr_cells;
    logic      [SLOTS-1:0]             rd_act;
    logic      [SLOTS-1:0]             wr_act;
    logic      [SLOTS-1:0]             wr_be;
    logic      [SLOTS-1:0][CELL_W-1:0] rd_bytes;
    logic      [SLOTS-1:0][CELL_W-1:0] wr_bytes;
    logic      [DATA_W-1:0]            rd_next;
    logic                              array_we;

    vrf2d_addr_gen #(.N_LANES(LANES), .N_BYTES(MAX_BYTES), .STRIDE(WIDE_STRIDE)) u_rd_addr (
        .req    (rd_req),
        .cells  (rd_cells),
        .active (rd_act)
    );

    vrf2d_addr_gen #(.N_LANES(LANES), .N_BYTES(MAX_BYTES), .STRIDE(WIDE_STRIDE)) u_wr_addr (
        .req    (wr_req),
        .cells  (wr_cells),
        .active (wr_act)
    );

    // slot s = lane*MAX_BYTES + byte, which is also its byte position in the data bus
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign wr_be[s]                    = wr_lane_en[s / MAX_BYTES] & wr_act[s];
        assign wr_bytes[s]                 = wr_data[s*CELL_W +: CELL_W];
        assign rd_next[s*CELL_W +: CELL_W] = rd_act[s] ? rd_bytes[s] : '0;
    end

    assign array_we = wr_en & ~rst;

    vrf2d_cell_array #(.N_ROWS(ROWS), .N_COLS(COLS), .N_SLOTS(SLOTS)) u_cells (
        .clk   (clk),
        .we    (array_we),
        .wcell (wr_cells),
        .wbe   (wr_be),
        .wbyte (wr_bytes),
        .rcell (rd_cells),
        .rbyte (rd_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_next;
            end
        end
    end
endmodule

// File: rtl/vrf2d_chk.sv
module vrf2d_chk
    import vrf2d_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [1:0]        rd_width,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);
    function automatic logic [DATA_W-1:0] upper_mask(int keep_bytes);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int j = keep_bytes * CELL_W; j < LANE_W; j++) begin
                m[l*LANE_W + j] = 1'b1;
            end
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] HI_OF_B8  = upper_mask(1);
    localparam logic [DATA_W-1:0] HI_OF_B16 = upper_mask(2);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!rd_valid && rd_data == '0));

    // R2
    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R2
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    // R2
    a_r2_data_holds: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R7
    a_r7_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_width == 2'd0) |=> ((rd_data & HI_OF_B8) == '0));

    // R5
    a_r5_half_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_width == 2'd1) |=> ((rd_data & HI_OF_B16) == '0));
endmodule

bind vrf2d_top vrf2d_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_width (rd_width),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/vrf2d_top_tb_top.sv
`timescale 1ns/1ps
module vrf2d_top_tb_top;
    localparam int DW = 512;

    logic            clk = 1'b0;
    logic            rst;
    logic            rd_en, rd_vert, rd_off_en;
    logic [5:0]      rd_y, rd_x;
    logic [1:0]      rd_width;
    logic [11:0]     rd_off;
    logic            rd_valid;
    logic [DW-1:0]   rd_data;
    logic            wr_en, wr_vert, wr_off_en;
    logic [5:0]      wr_y, wr_x;
    logic [1:0]      wr_width;
    logic [11:0]     wr_off;
    logic [15:0]     wr_lane_en;
    logic [DW-1:0]   wr_data;

    always #4 clk = ~clk;

    vrf2d_top dut_i (
        .clk(clk), .rst(rst),
        .rd_en(rd_en), .rd_y(rd_y), .rd_x(rd_x), .rd_vert(rd_vert),
        .rd_width(rd_width), .rd_off_en(rd_off_en), .rd_off(rd_off),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_y(wr_y), .wr_x(wr_x), .wr_vert(wr_vert),
        .wr_width(wr_width), .wr_off_en(wr_off_en), .wr_off(wr_off),
        .wr_lane_en(wr_lane_en), .wr_data(wr_data)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    started  = 0;
    string rd_tag   = "R3";

    // behavioural reference
    logic [7:0]    ref_mem [64][64];
    logic          exp_valid = 1'b0;
    logic [DW-1:0] exp_data  = '0;
    string         exp_tag   = "R1";

    function automatic int nbytes(logic [1:0] w);
        return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            exp_valid = 1'b0;
            exp_data  = '0;
            exp_tag   = "R1";
        end else begin
            if (rd_en) begin
                int by, bx;
                by = (rd_y + (rd_off_en ? int'(rd_off[11:6]) : 0)) % 64;
                bx = (rd_x + (rd_off_en ? int'(rd_off[5:0]) : 0)) % 64;
                exp_data  = '0;
                exp_valid = 1'b1;
                exp_tag   = rd_tag;
                for (int k = 0; k < 16; k++) begin
                    for (int b = 0; b < nbytes(rd_width); b++) begin
                        int r, c;
                        r = rd_vert ? (by + k) % 64 : by;
                        c = rd_vert ? (bx + 16*b) % 64 : (bx + k + 16*b) % 64;
                        exp_data[k*32 + b*8 +: 8] = ref_mem[r][c];
                    end
                end
            end else begin
                exp_valid = 1'b0;
                exp_tag   = "R2";
            end
            if (wr_en) begin
                int by, bx;
                by = (wr_y + (wr_off_en ? int'(wr_off[11:6]) : 0)) % 64;
                bx = (wr_x + (wr_off_en ? int'(wr_off[5:0]) : 0)) % 64;
                for (int k = 0; k < 16; k++) begin
                    if (wr_lane_en[k]) begin
                        for (int b = 0; b < nbytes(wr_width); b++) begin
                            int r, c;
                            r = wr_vert ? (by + k) % 64 : by;
                            c = wr_vert ? (bx + 16*b) % 64 : (bx + k + 16*b) % 64;
                            ref_mem[r][c] = wr_data[k*32 + b*8 +: 8];
                        end
                    end
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            n_checks++;
            if (rd_valid !== exp_valid) begin
                n_fail++;
                $display("FAIL R2: rd_valid actual %b expected %b", rd_valid, exp_valid);
            end
            n_checks++;
            if (rd_data !== exp_data) begin
                n_fail++;
                $display("FAIL %s: rd_data actual %h expected %h", exp_tag, rd_data, exp_data);
            end
        end
    end

    task automatic idle();
        rd_en = 0; rd_y = '0; rd_x = '0; rd_vert = 0; rd_width = '0;
        rd_off_en = 0; rd_off = '0;
        wr_en = 0; wr_y = '0; wr_x = '0; wr_vert = 0; wr_width = '0;
        wr_off_en = 0; wr_off = '0; wr_lane_en = '0; wr_data = '0;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] rand_vec();
        logic [DW-1:0] v;
        for (int i = 0; i < DW/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic rd_req(input int y, input int x, input bit v, input int w,
                          input bit oe, input int off, input string tag);
        rd_en = 1; rd_y = 6'(y); rd_x = 6'(x); rd_vert = v; rd_width = 2'(w);
        rd_off_en = oe; rd_off = 12'(off); rd_tag = tag;
    endtask

    task automatic wr_req(input int y, input int x, input bit v, input int w,
                          input bit oe, input int off, input logic [15:0] le,
                          input logic [DW-1:0] d);
        wr_en = 1; wr_y = 6'(y); wr_x = 6'(x); wr_vert = v; wr_width = 2'(w);
        wr_off_en = oe; wr_off = 12'(off); wr_lane_en = le; wr_data = d;
    endtask

    // one-cycle read, then an idle cycle so the result is compared
    task automatic one_read(input int y, input int x, input bit v, input int w,
                            input bit oe, input int off, input string tag);
        cyc(); idle(); rd_req(y, x, v, w, oe, off, tag);
        cyc(); idle();
    endtask

    initial begin
        idle();
        rst = 1;
        // R1: reset state and no write during reset
        cyc(); wr_req(0, 0, 0, 2, 0, 0, 16'hFFFF, rand_vec());
        cyc(); cyc();
        idle();
        rst = 0;

        // fill every cell (R3 byte writes along rows); idle reads check R2 hold
        for (int y = 0; y < 64; y++) begin
            for (int q = 0; q < 4; q++) begin
                cyc(); idle(); wr_req(y, q*16, 0, 0, 0, 0, 16'hFFFF, rand_vec());
            end
        end
        cyc(); idle();

        one_read(5, 3, 0, 0, 0, 0, "R3");
        one_read(5, 3, 0, 0, 0, 0, "R7");
        one_read(7, 10, 0, 1, 0, 0, "R5");
        one_read(9, 0, 0, 2, 0, 0, "R6");
        one_read(9, 5, 0, 3, 0, 0, "R6");
        one_read(2, 5, 1, 0, 0, 0, "R4");
        one_read(40, 33, 1, 1, 0, 0, "R4");
        one_read(20, 7, 1, 2, 0, 0, "R4");
        one_read(1, 2, 0, 2, 1, (3 << 6) | 7, "R8");
        one_read(1, 2, 1, 1, 1, (50 << 6) | 40, "R8");
        one_read(1, 2, 0, 2, 0, 12'hFFF, "R8");
        one_read(60, 60, 0, 2, 0, 0, "R9");
        one_read(55, 50, 1, 2, 1, (20 << 6) | 30, "R9");

        // R10: partial lane mask, vertical 16-bit write, then read back
        cyc(); idle(); wr_req(10, 20, 1, 1, 0, 0, 16'hA5A5, rand_vec());
        cyc(); idle();
        one_read(10, 20, 1, 2, 0, 0, "R10");
        cyc(); idle(); wr_req(3, 61, 0, 2, 0, 0, 16'h0F01, rand_vec());
        cyc(); idle();
        one_read(3, 61, 0, 2, 0, 0, "R10");

        // R11: read and write the same cells in one cycle
        cyc(); idle();
        rd_req(30, 30, 0, 2, 0, 0, "R11");
        wr_req(30, 30, 0, 2, 0, 0, 16'hFFFF, rand_vec());
        cyc(); idle();
        one_read(30, 30, 0, 2, 0, 0, "R11");

        // R12: write inputs active but wr_en low
        cyc(); idle(); wr_req(12, 12, 0, 2, 0, 0, 16'hFFFF, rand_vec()); wr_en = 0;
        cyc(); idle();
        one_read(12, 12, 0, 2, 0, 0, "R12");

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            cyc(); idle();
            if ($urandom % 2 == 1) begin
                bit v;
                v = 1'($urandom);
                rd_req(int'($urandom % 64), int'($urandom % 64), v, int'($urandom % 4),
                       1'($urandom), int'($urandom % 4096), v ? "R4" : "R3");
            end
            wr_req(int'($urandom % 64), int'($urandom % 64), 1'($urandom),
                   int'($urandom % 4), 1'($urandom), int'($urandom % 4096),
                   16'($urandom), rand_vec());
            if ($urandom % 3 == 0) wr_en = 0;
        end
        cyc(); idle();
        cyc(); cyc();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule